// File: doc/BRIEF.md
# Exception Capture and Redirect Unit

This block sits next to a multicycle controller and watches two fault strobes. One strobe flags an instruction encoding the decoder does not accept. The other flags an ALU arithmetic overflow. A fault counts only when the controller's step enable is high. On a counted fault, the block records the address of the faulting instruction in an exception-PC register and a fault code in a cause register. In the next cycle it asserts a program-counter override strobe that carries a single fixed handler address. In that same cycle it pulses an abort line, which sends the controller back to its fetch state.

The PC presented to the block has already been advanced by one instruction word during fetch. The saved address is therefore the presented PC minus the step. While a fault is present, a combinational kill output blocks the register-file write of the faulting instruction. This stops an overflowing result from being committed. Handlers are not vectored, and return from a handler is handled elsewhere.

Top module: `exc_redirect_unit`

## Requirements
- R1: After reset, epc_o and cause_o read 0, and abort_o and pc_ovr_we_o are low.
- R2: A fault is counted at a rising clock edge when step_en_i is high, abort_o is low, and undef_i or ovf_i is high. On that edge epc_o becomes pc_i minus 4, modulo 2^XLEN. For example, pc_i of 0 saves 0xFFFFFFFC.
- R3: A counted fault with only ovf_i high writes cause code 1 to cause_o.
- R4: A counted fault with undef_i high writes cause code 0 to cause_o, whatever the value of ovf_i.
- R5: abort_o and pc_ovr_we_o are high for exactly the one cycle after the edge that counted a fault, and low otherwise. pc_ovr_o always carries the handler address 0xC0000000.
- R6: When step_en_i is low, the fault strobes have no effect: epc_o and cause_o hold, and no abort follows.
- R7: A fault presented while abort_o is high is ignored: registers hold and abort_o drops in the following cycle.
- R8: epc_o and cause_o change only on an edge that counts a fault.
- R9: wr_kill_o equals step_en_i AND (undef_i OR ovf_i) in the same cycle, with no register delay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| step_en_i | input | 1 | Controller step enable; qualifies both fault strobes |
| pc_i | input | XLEN | Current PC, already advanced past the instruction |
| undef_i | input | 1 | Undefined instruction encoding strobe |
| ovf_i | input | 1 | ALU arithmetic overflow strobe |
| epc_o | output | XLEN | Saved address of the faulting instruction |
| cause_o | output | XLEN | Fault code: 0 undefined, 1 overflow |
| pc_ovr_o | output | XLEN | Handler address to load into the PC |
| pc_ovr_we_o | output | 1 | PC override strobe |
| abort_o | output | 1 | One-cycle return-to-fetch pulse |
| wr_kill_o | output | 1 | Suppresses the faulting instruction's register write |

## Verification
The bench uses the default parameters: a 32-bit word, a step of 4 and the 0xC0000000 handler. At this width the subtract-by-step wraps when the PC is below 4. A directed case with PC 0 exercises that wrap. Random PCs and strobe mixes then cover the priority rule when both faults fire together. They also cover faults that arrive inside the abort cycle and faults gated off by a low step enable.

// File: rtl/exc_pkg.sv
package exc_pkg;
  typedef enum logic [0:0] {
    CAUSE_UNDEF = 1'b0,
    CAUSE_OVF   = 1'b1
  } cause_e;
endpackage

// File: rtl/exc_prio.sv
module exc_prio
  import exc_pkg::*;
(
  input  logic   step_en_i,
  input  logic   undef_i,
  input  logic   ovf_i,
  output logic   fault_o,
  output cause_e code_o
);
  always_comb begin
    fault_o = step_en_i & (undef_i | ovf_i);
    // undefined encoding wins over overflow
    code_o  = undef_i ? CAUSE_UNDEF : CAUSE_OVF;
  end
endmodule

// File: rtl/exc_redirect_ctl.sv
module exc_redirect_ctl (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic fault_i,
  output logic capture_o,
  output logic abort_o
);
  logic abort_q;

  // faults seen during the abort cycle are dropped
  assign capture_o = fault_i & ~abort_q;
  assign abort_o   = abort_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) abort_q <= 1'b0;
    else         abort_q <= capture_o;
  end

  AST_ABORT_ONE_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    abort_q |=> !abort_q); // R5
  AST_ABORT_FOLLOWS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    capture_o |=> abort_q); // R5
  AST_ABORT_MASK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (abort_q && fault_i) |=> !abort_q); // R7
endmodule

// File: rtl/exc_state_regs.sv
module exc_state_regs
  import exc_pkg::*;
#(
  parameter int unsigned XLEN    = 32,
  parameter int unsigned PC_STEP = 4
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            capture_i,
  input  cause_e          code_i,
  input  logic [XLEN-1:0] pc_i,
  output logic [XLEN-1:0] epc_o,
  output logic [XLEN-1:0] cause_o
);
  localparam logic [XLEN-1:0] STEP = XLEN'(PC_STEP);

  logic [XLEN-1:0] epc_q, cause_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      epc_q   <= '0;
      cause_q <= '0;
    end else if (capture_i) begin
      epc_q   <= pc_i - STEP;
      cause_q <= XLEN'(code_i);
    end
  end

  assign epc_o   = epc_q;
  assign cause_o = cause_q;

  AST_EPC_VALUE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    capture_i |=> (epc_q + STEP == $past(pc_i))); // R2
  AST_CAUSE_CODE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (capture_i && code_i == CAUSE_OVF) |=> (cause_q == XLEN'(1))); // R3
  AST_HOLD_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !capture_i |=> ($stable(epc_q) && $stable(cause_q))); // R8
endmodule

// File: rtl/exc_redirect_unit.sv
module exc_redirect_unit
  import exc_pkg::*;
#(
  parameter int unsigned     XLEN         = 32,
  parameter int unsigned     PC_STEP      = 4,
  parameter logic [XLEN-1:0] HANDLER_ADDR = 32'hC000_0000
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            step_en_i,
  input  logic [XLEN-1:0] pc_i,
  input  logic            undef_i,
  input  logic            ovf_i,
  output logic [XLEN-1:0] epc_o,
  output logic [XLEN-1:0] cause_o,
  output logic [XLEN-1:0] pc_ovr_o,
  output logic            pc_ovr_we_o,
  output logic            abort_o,
  output logic            wr_kill_o
);
  logic   fault, capture;
  cause_e code;

  exc_prio u_prio (
    .step_en_i (step_en_i),
    .undef_i   (undef_i),
    .ovf_i     (ovf_i),
    .fault_o   (fault),
    .code_o    (code)
  );

  exc_redirect_ctl u_ctl (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .fault_i   (fault),
    .capture_o (capture),
    .abort_o   (abort_o)
  );

  exc_state_regs #(.XLEN(XLEN), .PC_STEP(PC_STEP)) u_regs (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .capture_i (capture),
    .code_i    (code),
    .pc_i      (pc_i),
    .epc_o     (epc_o),
    .cause_o   (cause_o)
  );

  assign pc_ovr_o    = HANDLER_ADDR;
  assign pc_ovr_we_o = abort_o;
  assign wr_kill_o   = fault;

  AST_UNDEF_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_en_i && undef_i && !abort_o) |=> (cause_o == '0)); // R4
  AST_NO_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!step_en_i && !abort_o) |=> !abort_o); // R6
endmodule

// File: tb/exc_redirect_unit_tb.sv
module exc_redirect_unit_tb_top;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        step_en_i = 1'b0;
  logic [31:0] pc_i = '0;
  logic        undef_i = 1'b0;
  logic        ovf_i = 1'b0;
  logic [31:0] epc_o, cause_o, pc_ovr_o;
  logic        pc_ovr_we_o, abort_o, wr_kill_o;

  int checks = 0;
  int errors = 0;
  logic [31:0] m_epc = '0, m_cause = '0;
  logic        m_abort = 1'b0;

  always #5 clk_i = ~clk_i;

  exc_redirect_unit dut_i (.*);

  function automatic logic [31:0] f_epc(input logic [31:0] pc);
    return pc - 32'd4;
  endfunction

  function automatic logic [31:0] f_cause(input logic u);
    return u ? 32'd0 : 32'd1;
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic chk_state(input string req);
    chk({req, " epc"}, epc_o, m_epc);
    chk({req, " cause"}, cause_o, m_cause);
    chk({req, " abort"}, {31'd0, abort_o}, {31'd0, m_abort});
    chk({req, " R5 ovr_we"}, {31'd0, pc_ovr_we_o}, {31'd0, m_abort});
    chk("R5 ovr_addr", pc_ovr_o, 32'hC000_0000);
  endtask

  // drive at negedge, check kill, clock, update model, check state
  task automatic step(input logic en, input logic [31:0] pc, input logic u,
                      input logic o, input string req);
    logic fire;
    step_en_i = en; pc_i = pc; undef_i = u; ovf_i = o;
    #1;
    chk("R9 kill", {31'd0, wr_kill_o}, {31'd0, en & (u | o)});
    fire = en && (u || o) && !m_abort;
    @(posedge clk_i);
    if (fire) begin
      m_epc = f_epc(pc);
      m_cause = f_cause(u);
    end
    m_abort = fire;
    @(negedge clk_i);
    chk_state(req);
  endtask

  initial begin
    void'($urandom(32'd1234));
    #3;
    chk_state("R1 reset");
    #20 rst_ni = 1'b1;
    @(negedge clk_i);
    chk_state("R1 after release");

    step(1, 32'h0000_1008, 1, 0, "R2 undef");
    step(0, 32'h0, 0, 0, "R5 drop");
    step(1, 32'h0000_2000, 0, 1, "R3 ovf");
    step(0, 32'h0, 0, 0, "R8 hold");
    step(1, 32'h0000_3004, 1, 1, "R4 both");
    step(1, 32'h0000_4000, 0, 1, "R7 during abort");
    step(0, 32'h0000_5000, 1, 1, "R6 no step");
    step(0, 32'h0, 0, 0, "R6 idle");
    step(1, 32'h0000_0000, 0, 1, "R2 wrap");
    step(1, 32'h0000_0010, 0, 0, "R8 no fault");
    step(1, 32'h0000_0020, 0, 0, "R8 no fault");

    for (int i = 0; i < 400; i++) begin
      logic en, u, o;
      logic [31:0] r;
      r  = $urandom;
      en = (r[1:0] != 2'b00);
      u  = (r[4:2] == 3'd0);
      o  = (r[7:5] == 3'd0);
      step(en, $urandom, u, o, "R2 R3 R4 R7 rand");
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #1_000_000;
    checks++;
    errors++;
    $display("FAIL watchdog act=timeout exp=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule